// File: doc/BRIEF.md
# External and Nonmaskable Interrupt Pin Capture with Power-Mode Wake

This block sits between two external interrupt pins and the interrupt and power sequencers of a microcontroller core. The two pins are a general external interrupt and a nonmaskable interrupt. Each pin goes through a two-flop synchronizer. It is then sampled once per state time, on a phase strobe that stands for the high half of the output clock. A rising edge between two consecutive samples produces a one-cycle pending-flag set pulse.

The block also decides whether a pin event ends a low-power mode. In idle, an enabled external edge or any nonmaskable edge raises a wake request, and the service routine runs first. In powerdown, only the external pin can wake the device, and the enable plays no part in that decision. The wake works on the pin level, and a combinational wake output reaches the oscillator restart logic before any clock runs. The synchronized wake request carries a flag. This flag tells the sequencer either to run the external interrupt routine first or to resume after the powerdown instruction.

Top module: `irqwake_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ext_set_o`, `nmi_set_o`, `wake_req_o` and `svc_first_o` are low.
- R2: With `pmode_i` = 0 (run), a rising edge on the external pin gives exactly one `ext_set_o` pulse. The value of `ext_en_i` does not matter. A pin held high gives no further pulses.
- R3: An external-pin high level lasting `STATE_CYC` clock cycles is captured whatever its phase relative to the sampling strobe.
- R4: In run mode, a nonmaskable rising edge gives one `nmi_set_o` pulse and no wake request.
- R5: With `pmode_i` = 1 (idle), an external edge always pulses `ext_set_o`. In the same cycle, `wake_req_o` and `svc_first_o` are raised only when `ext_en_i` is 1.
- R6: In idle, a nonmaskable edge pulses `nmi_set_o`, `wake_req_o` and `svc_first_o` together.
- R7: With `pmode_i` = 2 (powerdown), a high synchronized external level raises `wake_req_o` whatever the value of `ext_en_i`. In that cycle, `svc_first_o` and `ext_set_o` both equal `ext_en_i`.
- R8: The powerdown wake is level-triggered. A pin that is already high when powerdown is entered wakes the device. At most one wake is issued per powerdown stay.
- R9: In powerdown, nonmaskable edges produce neither `nmi_set_o` nor `wake_req_o`.
- R10: `wake_async_o` is high, without any clock edge, exactly while the raw external pin is high and `pmode_i` is 2.
- R11: `pmode_i` = 3 behaves like run mode.
- R12: Leaving powerdown with the external pin still high produces no external edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| ext_pin_i | input | 1 | Raw external interrupt pin |
| nmi_pin_i | input | 1 | Raw nonmaskable interrupt pin |
| ext_en_i | input | 1 | External interrupt enable |
| pmode_i | input | 2 | Power mode: 0 run, 1 idle, 2 powerdown, 3 as run |
| ext_set_o | output | 1 | One-cycle set pulse for the external pending flag |
| nmi_set_o | output | 1 | One-cycle nonmaskable request (vector fetch) |
| wake_req_o | output | 1 | Synchronized one-cycle wake request |
| svc_first_o | output | 1 | Valid with wake: 1 = service first, 0 = resume after powerdown instruction |
| wake_async_o | output | 1 | Unclocked powerdown wake level for oscillator restart |

## Verification
The bench sends pulses exactly one state time wide at two phase offsets. A design that sampled less often, or on only one phase, would lose one of them. It enters powerdown with the pin already high, and it toggles the pin again during the same stay. An edge-triggered powerdown path would never wake, and a path that did not remember its wake would issue a second one. It fires the nonmaskable pin in powerdown, where any event is a failure. It also returns to run mode with the pin held high; logic that stopped tracking samples during powerdown would invent a false external edge there.

// File: rtl/irqwake_pkg.sv
package irqwake_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2,
        PM_RSVD = 2'd3
    } pmode_e;

    localparam int NUM_PINS = 2;
    localparam int PIN_EXT  = 0;
    localparam int PIN_NMI  = 1;

    typedef struct packed {
        logic ext_set;
        logic nmi_set;
        logic wake;
        logic svc_first;
        logic pd_done;
    } evt_s;

endpackage

// File: rtl/irqwake_phase.sv
module irqwake_phase #(
    parameter int STATE_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic strobe_o
);
    localparam int CW = (STATE_CYC > 1) ? $clog2(STATE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STATE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign strobe_o = (cnt_q == LAST);
endmodule

// File: rtl/irqwake_sync.sv
module irqwake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic lvl_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= ff_d;
    end

    assign lvl_o = ff_q[STAGES-1];
endmodule

// File: rtl/irqwake_edge.sv
module irqwake_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic lvl_i,
    output logic rise_o
);
    logic smp_d, smp_q;

    always_comb begin
        smp_d = strobe_i ? lvl_i : smp_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) smp_q <= 1'b0;
        else         smp_q <= smp_d;
    end

    assign rise_o = strobe_i & lvl_i & ~smp_q;
endmodule

// File: rtl/irqwake_top.sv
module irqwake_top
    import irqwake_pkg::*;
#(
    parameter int STATE_CYC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ext_pin_i,
    input  logic       nmi_pin_i,
    input  logic       ext_en_i,
    input  logic [1:0] pmode_i,
    output logic       ext_set_o,
    output logic       nmi_set_o,
    output logic       wake_req_o,
    output logic       svc_first_o,
    output logic       wake_async_o
);
    logic                strobe;
    logic [NUM_PINS-1:0] pins, lvl, rise;

    assign pins[PIN_EXT] = ext_pin_i;
    assign pins[PIN_NMI] = nmi_pin_i;

    irqwake_phase #(.STATE_CYC(STATE_CYC)) u_phase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_o (strobe)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        irqwake_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (pins[g]),
            .lvl_o  (lvl[g])
        );
        irqwake_edge u_edge (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .strobe_i (strobe),
            .lvl_i    (lvl[g]),
            .rise_o   (rise[g])
        );
    end

    evt_s evt_d, evt_q;
    logic in_idle, in_down, idle_wake, pd_fire;

    always_comb begin
        in_idle   = (pmode_i == PM_IDLE);
        in_down   = (pmode_i == PM_DOWN);
        idle_wake = in_idle & ((rise[PIN_EXT] & ext_en_i) | rise[PIN_NMI]);
        pd_fire   = in_down & lvl[PIN_EXT] & ~evt_q.pd_done;

        evt_d.ext_set   = (rise[PIN_EXT] & ~in_down) | (pd_fire & ext_en_i);
        evt_d.nmi_set   = rise[PIN_NMI] & ~in_down;
        evt_d.wake      = idle_wake | pd_fire;
        evt_d.svc_first = idle_wake | (pd_fire & ext_en_i);
        evt_d.pd_done   = in_down & (evt_q.pd_done | pd_fire);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) evt_q <= '0;
        else         evt_q <= evt_d;
    end

    assign ext_set_o    = evt_q.ext_set;
    assign nmi_set_o    = evt_q.nmi_set;
    assign wake_req_o   = evt_q.wake;
    assign svc_first_o  = evt_q.svc_first;
    assign wake_async_o = ext_pin_i & (pmode_i == PM_DOWN);
endmodule

// File: rtl/irqwake_chk.sv
module irqwake_chk
    import irqwake_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       ext_pin_i,
    input logic       ext_en_i,
    input logic [1:0] pmode_i,
    input logic       ext_set_o,
    input logic       nmi_set_o,
    input logic       wake_req_o,
    input logic       svc_first_o,
    input logic       wake_async_o
);
    // R9
    nmi_not_in_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_set_o |-> ($past(pmode_i) != PM_DOWN));

    // R4
    no_wake_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_req_o |-> ($past(pmode_i) == PM_IDLE || $past(pmode_i) == PM_DOWN));

    // R6
    idle_wake_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_req_o && $past(pmode_i) == PM_IDLE) |-> svc_first_o);

    // R7
    down_wake_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_req_o && $past(pmode_i) == PM_DOWN) |-> (svc_first_o == $past(ext_en_i)));

    // R8
    single_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_req_o |=> !wake_req_o);

    // R5
    svc_needs_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        svc_first_o |-> wake_req_o);

    // R10
    async_only_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pmode_i != PM_DOWN || !ext_pin_i) |-> !wake_async_o);
endmodule

bind irqwake_top irqwake_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_pin_i    (ext_pin_i),
    .ext_en_i     (ext_en_i),
    .pmode_i      (pmode_i),
    .ext_set_o    (ext_set_o),
    .nmi_set_o    (nmi_set_o),
    .wake_req_o   (wake_req_o),
    .svc_first_o  (svc_first_o),
    .wake_async_o (wake_async_o)
);

// File: tb/test_irqwake_top.sv
module test_irqwake_top;
    localparam int STATE_CYC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       ext_en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       ext_set, nmi_set, wake, svc, wake_async;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [3:0] expq[$];
    logic [3:0] got, exp_item;
    string cur_req = "R1";

    irqwake_top #(.STATE_CYC(STATE_CYC)) i_irqwake_top (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ext_pin_i    (ext_pin),
        .nmi_pin_i    (nmi_pin),
        .ext_en_i     (ext_en),
        .pmode_i      (mode),
        .ext_set_o    (ext_set),
        .nmi_set_o    (nmi_set),
        .wake_req_o   (wake),
        .svc_first_o  (svc),
        .wake_async_o (wake_async)
    );

    always #2.5 clk = ~clk;

    // monitor: item = {ext_set, nmi_set, wake, svc_first}
    always @(negedge clk) begin
        if (rst_n && !done) begin
            got = {ext_set, nmi_set, wake, svc};
            if (got[3:1] != 3'b000) begin
                n_tests++;
                if (expq.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s unexpected event actual=%b expected=none", cur_req, got);
                end else begin
                    exp_item = expq.pop_front();
                    if (got !== exp_item) begin
                        n_fail++;
                        $display("FAIL %s event actual=%b expected=%b", cur_req, got, exp_item);
                    end
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(input string r);
        cyc(30);
        n_tests++;
        if (expq.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing events actual=%0d outstanding expected=0", r, expq.size());
            expq.delete();
        end
    endtask

    task automatic check1(input string r, input logic act, input logic expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", r, act, expv);
        end
    endtask

    task automatic pulse_ext(input int w);
        ext_pin = 1'b1;
        cyc(w);
        ext_pin = 1'b0;
    endtask

    task automatic pulse_nmi(input int w);
        nmi_pin = 1'b1;
        cyc(w);
        nmi_pin = 1'b0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        cyc(3);
        // R1: outputs idle during reset
        check1("R1", ext_set | nmi_set | wake | svc, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        check1("R1", ext_set | nmi_set | wake | svc, 1'b0);
        cyc(5);

        // R2: run-mode edge, enable off, held high for many cycles
        cur_req = "R2"; ext_en = 1'b0; expq.push_back(4'b1000);
        pulse_ext(12); settle("R2");

        // R3: pulse exactly one state time wide, two phase offsets
        cur_req = "R3"; expq.push_back(4'b1000);
        pulse_ext(STATE_CYC); settle("R3");
        cyc(1);
        expq.push_back(4'b1000);
        pulse_ext(STATE_CYC); settle("R3");

        // R4: nonmaskable edge in run mode
        cur_req = "R4"; expq.push_back(4'b0100);
        pulse_nmi(STATE_CYC + 1); settle("R4");

        // R11: reserved mode acts as run
        cur_req = "R11"; mode = 2'd3; cyc(5); expq.push_back(4'b1000);
        pulse_ext(4); settle("R11");

        // R5: idle, enabled and disabled
        cur_req = "R5"; mode = 2'd1; ext_en = 1'b1; cyc(5);
        expq.push_back(4'b1011);
        pulse_ext(4); settle("R5");
        ext_en = 1'b0; expq.push_back(4'b1000);
        pulse_ext(4); settle("R5");

        // R6: idle nonmaskable wake
        cur_req = "R6"; expq.push_back(4'b0111);
        pulse_nmi(4); settle("R6");

        // R10 + R7: powerdown, enable off
        cur_req = "R10"; mode = 2'd2; cyc(5);
        check1("R10", wake_async, 1'b0);
        ext_pin = 1'b1; #1;
        check1("R10", wake_async, 1'b1);
        cur_req = "R7"; expq.push_back(4'b0010);
        settle("R7");
        ext_pin = 1'b0; cyc(5);
        check1("R10", wake_async, 1'b0);

        // R9: nonmaskable ignored in powerdown
        cur_req = "R9"; mode = 2'd0; cyc(5); mode = 2'd2; cyc(5);
        pulse_nmi(6); settle("R9");

        // R7: powerdown with enable on
        cur_req = "R7"; mode = 2'd0; cyc(5); ext_en = 1'b1; mode = 2'd2; cyc(5);
        expq.push_back(4'b1011);
        pulse_ext(4); settle("R7");

        // R8: one wake per stay
        cur_req = "R8"; pulse_ext(4); settle("R8");

        // R8: pin already high when powerdown is entered
        cur_req = "R2"; mode = 2'd0; ext_en = 1'b0; cyc(5);
        expq.push_back(4'b1000);
        ext_pin = 1'b1; settle("R2");
        cur_req = "R8"; mode = 2'd2; expq.push_back(4'b0010);
        settle("R8");

        // R12: back to run with the pin still high
        cur_req = "R12"; mode = 2'd0; settle("R12");
        ext_pin = 1'b0; settle("R12");
        check1("R12", wake_async, 1'b0);

        summary();
    end
endmodule